// File: doc/BRIEF.md
# Bidirectional GPIO port with pull-up control

This block controls a bank of general-purpose pins. Software sees three register addresses: an output latch, a direction register, and a read-only view of the sampled pin levels. The port gives each pin three pad controls: drive enable, drive value and pull-up enable. A pin set as an output drives its latch bit. A pin set as an input uses its latch bit to turn the pull-up on or off. Pin inputs pass through a chain of synchronizer flops before software can read them.

Each pin also has two override inputs, so a neighbouring peripheral can take control of it. A serial transmitter can force its pin to drive a value the peripheral supplies. A serial receiver can force its pin to be an input; the latch bit still sets that pin's pull-up. The parameter `IMPL_MASK` states which bit positions exist. Positions outside the mask read as zero, ignore writes and never drive their pad.

Top module: `gpio_port_ctl`

## Requirements
- R1: With direction bit 1 and no override, the pin has pad_oe=1 and pad_pu=0, and pad_out equals its latch bit.
- R2: With direction bit 0 and no override, the pin has pad_oe=0 and pad_out=0, and pad_pu equals its latch bit. A pin never has pad_oe and pad_pu high together.
- R3: Read data is combinational from the address. Address 0 returns the latch, address 1 returns the direction register, address 2 returns the synchronized pin levels, and address 3 returns zero.
- R4: A write to address 2 or address 3 changes no register and no pad control.
- R5: Latch and direction reset to zero. While rst_n is low, pad_oe and pad_pu are zero from the moment reset asserts, with no clock edge needed. Reset release is synchronized to clk.
- R6: A level change on pin_in appears at address 2 exactly SYNC_STAGES rising clock edges later (default 2), and not before.
- R7: alt_force_out high on a pin gives pad_oe=1, pad_out=alt_out_val and pad_pu=0, whatever the direction bit holds.
- R8: alt_force_in high, with alt_force_out low, gives pad_oe=0 and pad_out=0, whatever the direction bit holds. pad_pu then equals the latch bit.
- R9: When alt_force_out and alt_force_in are both high on a pin, alt_force_out wins.
- R10: Bit positions where IMPL_MASK is 0 (bit 7 by default) always read as zero at every address and cannot be written. Their pad_oe, pad_out and pad_pu stay 0 whatever the inputs are.
- R11: A register updates at the rising edge where bus_wr is high and keeps its value while bus_wr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr |
| pin_in | input | WIDTH | Levels seen at the pads |
| alt_force_out | input | WIDTH | Per-pin peripheral request to drive the pin |
| alt_force_in | input | WIDTH | Per-pin peripheral request to make the pin an input |
| alt_out_val | input | WIDTH | Value a peripheral drives while forcing output |
| pad_oe | output | WIDTH | Per-pin drive enable |
| pad_out | output | WIDTH | Per-pin drive value |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
A register write and a peripheral override can change a pin's controls in the same cycle. The bench sets up this collision in one clock edge: a new latch value is written while a receive-style force-in is raised on pins whose direction bit is 1. It then checks that drive is dropped and that the pull-up follows the newly written latch bit, not the old one. A second case writes the direction register while a force-out is held. It checks that pad_oe stays high and that pad_out follows the peripheral value instead of the latch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_LATCH = 2'd0,
      SEL_DIR   = 2'd1,
      SEL_PINS  = 2'd2,
      SEL_VOID  = 2'd3
   } sel_e;

   typedef struct packed {
      logic oe;
      logic drv;
      logic pu;
   } padctl_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_sync_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_raw,
   output logic [WIDTH-1:0] pin_sync
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= pin_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH     = 8,
   parameter logic [WIDTH-1:0] IMPL_MASK = {1'b0, {(WIDTH-1){1'b1}}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pins_sync,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q
);
   sel_e sel;
   assign sel = sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_LATCH: latch_q <= wdata & IMPL_MASK;
            SEL_DIR:   dir_q   <= wdata & IMPL_MASK;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_LATCH: rdata = latch_q;
         SEL_DIR:   rdata = dir_q;
         SEL_PINS:  rdata = pins_sync & IMPL_MASK;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH     = 8,
   parameter logic [WIDTH-1:0] IMPL_MASK = {1'b0, {(WIDTH-1){1'b1}}}
) (
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] force_out,
   input  logic [WIDTH-1:0] force_in,
   input  logic [WIDTH-1:0] alt_val,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);
   padctl_t ctl [WIDTH];

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         always_comb begin
            if (!rst_n)            ctl[i] = '{oe: 1'b0, drv: 1'b0,       pu: 1'b0};
            else if (force_out[i]) ctl[i] = '{oe: 1'b1, drv: alt_val[i], pu: 1'b0};
            else if (force_in[i])  ctl[i] = '{oe: 1'b0, drv: 1'b0,       pu: latch_q[i]};
            else if (dir_q[i])     ctl[i] = '{oe: 1'b1, drv: latch_q[i], pu: 1'b0};
            else                   ctl[i] = '{oe: 1'b0, drv: 1'b0,       pu: latch_q[i]};
         end
         assign pad_oe[i]  = ctl[i].oe  & IMPL_MASK[i];
         assign pad_out[i] = ctl[i].drv & IMPL_MASK[i];
         assign pad_pu[i]  = ctl[i].pu  & IMPL_MASK[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH       = 8,
   parameter logic [WIDTH-1:0] IMPL_MASK   = {1'b0, {(WIDTH-1){1'b1}}},
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      RST_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   input  logic [WIDTH-1:0]  alt_force_out,
   input  logic [WIDTH-1:0]  alt_force_in,
   input  logic [WIDTH-1:0]  alt_out_val,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_pu
);
   generate
      if (WIDTH < 1)        begin : g_bad_width $error("WIDTH must be at least 1"); end
      if (SYNC_STAGES < 2)  begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (RST_STAGES < 2)   begin : g_bad_rst   $error("RST_STAGES must be at least 2"); end
      if (IMPL_MASK == '0)  begin : g_bad_mask  $error("IMPL_MASK selects no pin"); end
   endgenerate

   logic             rst_int_n;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;

   gpio_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (rst_int_n)
   );

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_pin_sync (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .pin_raw  (pin_in),
      .pin_sync (pins_sync)
   );

   gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) i_regs (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr        (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .pins_sync (pins_sync),
      .rdata     (bus_rdata),
      .latch_q   (latch_q),
      .dir_q     (dir_q)
   );

   gpio_pad_mux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) i_pad_mux (
      .rst_n     (rst_int_n),
      .latch_q   (latch_q),
      .dir_q     (dir_q),
      .force_out (alt_force_out),
      .force_in  (alt_force_in),
      .alt_val   (alt_out_val),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu)
   );
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
   parameter int unsigned      WIDTH     = 8,
   parameter logic [WIDTH-1:0] IMPL_MASK = {1'b0, {(WIDTH-1){1'b1}}}
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_int_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] alt_force_out,
   input logic [WIDTH-1:0] alt_force_in,
   input logic [WIDTH-1:0] alt_out_val,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu
);
   // R5: pads released while the external reset is low
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         a_r5_reset_tristate: assert ((pad_oe | pad_pu) == '0);
      end
   end

   // R2: drive and pull-up are exclusive
   a_r2_no_pullup_when_driving: assert property (@(posedge clk) disable iff (!rst_int_n)
      (pad_oe & pad_pu) == '0);

   // R7: force-out wins over the direction register
   a_r7_force_out_drives: assert property (@(posedge clk) disable iff (!rst_int_n)
      ((pad_oe & alt_force_out & IMPL_MASK) == (alt_force_out & IMPL_MASK)) &&
      ((pad_out & alt_force_out) == (alt_out_val & alt_force_out & IMPL_MASK)));

   // R8: force-in alone removes drive
   a_r8_force_in_releases: assert property (@(posedge clk) disable iff (!rst_int_n)
      (pad_oe & alt_force_in & ~alt_force_out) == '0);

   // R10: absent positions never drive or read non-zero
   a_r10_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
      (((pad_oe | pad_out | pad_pu | bus_rdata) & ~IMPL_MASK) == '0));

   // R3: void address reads zero
   a_r3_void_reads_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
      (bus_addr == 2'd3) |-> (bus_rdata == '0));

   // R4: writes to read-only or void addresses do not move the pads
   a_r4_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
      (bus_wr && bus_addr[1]) ##1 ($stable(alt_force_out) && $stable(alt_force_in) &&
                                   $stable(alt_out_val))
      |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rst_int_n     (rst_int_n),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_rdata     (bus_rdata),
   .alt_force_out (alt_force_out),
   .alt_force_in  (alt_force_in),
   .alt_out_val   (alt_out_val),
   .pad_oe        (pad_oe),
   .pad_out       (pad_out),
   .pad_pu        (pad_pu)
);

// File: tb/test_gpio_port_ctl.sv
module test_gpio_port_ctl;
   localparam int W = 8;
   localparam logic [W-1:0] MASK = 8'h7F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] alt_force_out = '0;
   logic [W-1:0] alt_force_in = '0;
   logic [W-1:0] alt_out_val = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ctl #(.WIDTH(W), .IMPL_MASK(MASK), .SYNC_STAGES(2)) i_gpio_port_ctl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .alt_force_out(alt_force_out), .alt_force_in(alt_force_in),
      .alt_out_val(alt_out_val), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   // {dir, latch, force_out, force_in, alt_val, exp_oe, exp_out, exp_pu}
   localparam logic [63:0] VEC [8] = '{
      {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h7F},
      {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h25, 8'h00},
      {8'hF0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h70, 8'h30, 8'h0C},
      {8'h00, 8'h0F, 8'h03, 8'h00, 8'h02, 8'h03, 8'h02, 8'h0C},
      {8'hFF, 8'hFF, 8'h00, 8'h0C, 8'h00, 8'h73, 8'h73, 8'h0C},
      {8'h00, 8'h01, 8'h81, 8'h01, 8'hFF, 8'h01, 8'h01, 8'h00},
      {8'h0F, 8'hAA, 8'h00, 8'h80, 8'h00, 8'h0F, 8'h0A, 8'h20}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic pads_chk(input string req, input logic [W-1:0] oe,
                           input logic [W-1:0] o, input logic [W-1:0] pu);
      #1;
      chk({req, " oe"}, pad_oe, oe);
      chk({req, " out"}, pad_out, o);
      chk({req, " pu"}, pad_pu, pu);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R5 reset state
      pads_chk("R5 reset", 8'h00, 8'h00, 8'h00);
      rd_chk("R5 latch reset", 2'd0, 8'h00);
      rd_chk("R5 dir reset", 2'd1, 8'h00);

      // Vector table: R1 R2 R7 R8 R9 R10
      for (int v = 0; v < 8; v++) begin
         alt_force_out = '0; alt_force_in = '0; alt_out_val = '0;
         wr_reg(2'd0, VEC[v][55:48]);
         wr_reg(2'd1, VEC[v][63:56]);
         alt_force_out = VEC[v][47:40];
         alt_force_in  = VEC[v][39:32];
         alt_out_val   = VEC[v][31:24];
         pads_chk($sformatf("R1/R2/R7/R8/R9 vec%0d", v), VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
         rd_chk("R10 latch readback", 2'd0, VEC[v][55:48] & MASK);
         rd_chk("R10 dir readback", 2'd1, VEC[v][63:56] & MASK);
      end
      alt_force_out = '0; alt_force_in = '0; alt_out_val = '0;

      // R6 synchronizer latency, R10 on pin reads
      wr_reg(2'd1, 8'h00);
      bus_addr = 2'd2;
      @(negedge clk);
      pin_in = 8'hD5;
      @(negedge clk);
      rd_chk("R6 one edge still old", 2'd2, 8'h00);
      @(negedge clk);
      rd_chk("R6 two edges new, R10 bit7 masked", 2'd2, 8'h55);

      // R3 void read, R4 writes ignored
      wr_reg(2'd0, 8'h12);
      wr_reg(2'd1, 8'h30);
      wr_reg(2'd2, 8'hFF);
      wr_reg(2'd3, 8'hFF);
      rd_chk("R4 latch untouched", 2'd0, 8'h12);
      rd_chk("R4 dir untouched", 2'd1, 8'h30);
      rd_chk("R3 void address", 2'd3, 8'h00);
      pads_chk("R4 pads untouched", 8'h30, 8'h10, 8'h02);

      // R11 strobe: data changes without strobe are not taken
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h6E;
      repeat (2) @(negedge clk);
      rd_chk("R11 hold without strobe", 2'd0, 8'h12);

      // Collision: latch write and force-in raised at the same edge (R8)
      wr_reg(2'd1, 8'h0F);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h05;
      alt_force_in = 8'h03;
      @(negedge clk);
      bus_wr = 1'b0;
      pads_chk("R8 collision", 8'h0C, 8'h04, 8'h01);
      alt_force_in = '0;

      // Collision: direction write while force-out held (R7)
      alt_force_out = 8'h01; alt_out_val = 8'h00;
      wr_reg(2'd1, 8'h00);
      pads_chk("R7 dir write under force", 8'h01, 8'h00, 8'h04);
      alt_force_out = '0;

      // R5 asynchronous assertion between edges
      wr_reg(2'd1, 8'h7F);
      wr_reg(2'd0, 8'h00);
      @(posedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      chk("R5 async oe", pad_oe, 8'h00);
      chk("R5 async pu", pad_pu, 8'h00);
      do_reset();
      rd_chk("R5 dir cleared", 2'd1, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule